// File: doc/BRIEF.md
# Selectable Mix-Factor Multiplier

This block scales or frequency-shifts a stream of signed 24-bit samples. Every accepted sample is multiplied by a signed fractional mix factor. The product is rounded, clipped to the sample width and presented one clock later. The factor comes from one of two sources, and both are controlled by the same pair of pins: a serial data wire and a frame wire.

While the frame wire is high, a new factor is shifted in one bit per clock, most significant bit first. When the frame wire falls, the shifted word becomes the active factor and the block uses that external value. If the frame wire stays low and the data wire is driven high, the block switches to an internal four-entry table of quarter-sample-rate sinusoid values. This moves the input spectrum by one quarter of the sample rate, which is how the block serves as the tuning stage of a down-converter ahead of a low-pass filter chain.

The factor is a two's-complement fraction with `MIX_W-1` fractional bits. The value +1 is represented by the largest positive code and -1 by its negation.

Top module: `tune_mixer`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `out_valid` is 0 and `out_data` is 0. Reset selects the external source with a factor of zero, so samples sent before any load produce 0.
- R2: `out_valid` equals `smp_valid` delayed by exactly one clock.
- R3: On each clock where `mix_frame` is high, `mix_sd` is shifted in MSB first. On the first clock where `mix_frame` is low after being high, the last `MIX_W` shifted bits become the factor and the external source is selected.
- R4: A sample accepted on the same clock that a new factor is committed uses the previous factor. Samples accepted on later clocks use the new one.
- R5: A clock where `mix_frame` is low, was also low on the previous clock, and `mix_sd` is high selects the table source. Entering the table source from the external source restarts the table at its first entry.
- R6: In table mode the factor steps through 0, +max (0x7FFFFF), 0, -max (0x800001) and then repeats. The table advances once per accepted sample and does not advance on clocks without a sample.
- R7: `out_data` = floor((x·m + 2^(MIX_W-2)) / 2^(MIX_W-1)), which is rounding half toward positive infinity. Here x is the sample and m is the factor, both signed.
- R8: A result above 2^23-1 is clipped to 0x7FFFFF, and a result below -2^23 is clipped to 0x800000.
- R9: While `mix_frame` is high, the selected source does not change. A sample taken in table mode during a serial load still uses the table.
- R10: On clocks following one without an accepted sample, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_data | input | 24 | Signed input sample |
| mix_sd | input | 1 | Serial factor bit, or table select when the frame is low |
| mix_frame | input | 1 | Serial frame; its falling edge commits the factor |
| out_valid | output | 1 | Product strobe |
| out_data | output | 24 | Rounded, clipped signed product |

## Verification
The assertions assume that the two mix pins change only between clock edges. They also assume that `mix_sd` is driven low on the clock where the frame falls whenever an external load is intended, because otherwise a table request could follow on the next clock. The stimulus drives every input on the falling clock edge. It returns `mix_sd` to 0 together with the frame at the end of each load, and it raises `mix_sd` with the frame low only when it means to request the table. Samples arrive either alone or on deliberately chosen commit and mode-change clocks, so each product maps to exactly one factor.

// File: rtl/mix_pkg.sv
package mix_pkg;

  // Source of the multiplier operand
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_ROM = 1'b1
  } mix_src_e;

  // Number of entries in the quarter-rate sinusoid table
  localparam int unsigned QTR_ENTRIES = 4;
  localparam int unsigned QTR_IDX_W   = $clog2(QTR_ENTRIES);

  typedef logic [QTR_IDX_W-1:0] qtr_idx_t;

endpackage

// File: rtl/mix_serial_load.sv
// Two-wire factor loader: shift while frame high, commit on frame fall,
// table request on a quiet frame with the data wire high.
module mix_serial_load #(
  parameter int unsigned MIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mix_sd,
  input  logic             mix_frame,
  output logic             load_pulse,
  output logic [MIX_W-1:0] load_word,
  output logic             rom_req
);

  logic [MIX_W-1:0] shreg;
  logic             frame_q;

  // Shift register, MSB arrives first so it ends at the top
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (mix_frame) begin
      shreg <= {shreg[MIX_W-2:0], mix_sd};
    end
  end

  // Previous frame level for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b0;
    end else begin
      frame_q <= mix_frame;
    end
  end

  // Commit strobe on the first low clock after a high frame
  assign load_pulse = frame_q && !mix_frame;
  assign load_word  = shreg;

  // Table request: frame low for two clocks with the data wire high
  assign rom_req = !frame_q && !mix_frame && mix_sd;

endmodule

// File: rtl/mix_quarter_rom.sv
// Quarter-sample-rate sinusoid: 0, +max, 0, -max.
module mix_quarter_rom #(
  parameter int unsigned MIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             advance,
  output logic [MIX_W-1:0] value
);

  import mix_pkg::*;

  localparam logic [MIX_W-1:0] POS_ONE = {1'b0, {(MIX_W-1){1'b1}}};
  localparam logic [MIX_W-1:0] NEG_ONE = ~POS_ONE + MIX_W'(1);

  logic [MIX_W-1:0] tbl [QTR_ENTRIES];
  qtr_idx_t         phase;

  // Table contents computed per entry
  for (genvar g = 0; g < QTR_ENTRIES; g++) begin : g_tbl
    if (g % 2 == 0) begin : g_zero
      assign tbl[g] = '0;
    end else if (g == 1) begin : g_pos
      assign tbl[g] = POS_ONE;
    end else begin : g_neg
      assign tbl[g] = NEG_ONE;
    end
  end

  // Phase counter: restart wins over advance
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
    end else if (advance) begin
      phase <= phase + qtr_idx_t'(1);
    end
  end

  assign value = tbl[phase];

endmodule

// File: rtl/mix_src_sel.sv
// Holds the source mode and the external factor register.
module mix_src_sel #(
  parameter int unsigned MIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_pulse,
  input  logic [MIX_W-1:0] load_word,
  input  logic             rom_req,
  output mix_pkg::mix_src_e src_mode,
  output logic [MIX_W-1:0] ext_factor,
  output logic             rom_enter
);

  import mix_pkg::*;

  // A completed load always has priority over a table request
  assign rom_enter = rom_req && !load_pulse && (src_mode == SRC_EXT);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_mode <= SRC_EXT;
    end else if (load_pulse) begin
      src_mode <= SRC_EXT;
    end else if (rom_req) begin
      src_mode <= SRC_ROM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_factor <= '0;
    end else if (load_pulse) begin
      ext_factor <= load_word;
    end
  end

endmodule

// File: rtl/mix_mult_stage.sv
// Signed multiply, round half up, clip, one register stage.
module mix_mult_stage #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned MIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [MIX_W-1:0]  factor,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int unsigned PROD_W = DATA_W + MIX_W;
  localparam int unsigned FRAC_W = MIX_W - 1;

  localparam logic signed [PROD_W-1:0] RND_ADD =
    PROD_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] OUT_MAX =
    (PROD_W'(1) <<< (DATA_W - 1)) - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] OUT_MIN = -(PROD_W'(1) <<< (DATA_W - 1));

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rounded;
  logic signed [PROD_W-1:0] scaled;
  logic        [DATA_W-1:0] clipped;

  always_comb begin
    prod    = PROD_W'(signed'(in_data)) * PROD_W'(signed'(factor));
    rounded = prod + RND_ADD;
    scaled  = rounded >>> FRAC_W;
    if (scaled > OUT_MAX) begin
      clipped = {1'b0, {(DATA_W-1){1'b1}}};
    end else if (scaled < OUT_MIN) begin
      clipped = {1'b1, {(DATA_W-1){1'b0}}};
    end else begin
      clipped = scaled[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  // Output holds between samples
  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
    end else if (in_valid) begin
      out_data <= clipped;
    end
  end

endmodule

// File: rtl/tune_mixer.sv
// Top: sample times selectable mix factor.
module tune_mixer #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned MIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              mix_sd,
  input  logic              mix_frame,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  import mix_pkg::*;

  logic             load_pulse;
  logic [MIX_W-1:0] load_word;
  logic             rom_req;
  mix_src_e         src_mode;
  logic [MIX_W-1:0] ext_factor;
  logic             rom_enter;
  logic [MIX_W-1:0] rom_value;
  logic             rom_active;
  logic [MIX_W-1:0] eff_factor;

  assign rom_active = (src_mode == SRC_ROM);

  mix_serial_load #(.MIX_W(MIX_W)) u_load (
    .clk        (clk),
    .rst        (rst),
    .mix_sd     (mix_sd),
    .mix_frame  (mix_frame),
    .load_pulse (load_pulse),
    .load_word  (load_word),
    .rom_req    (rom_req)
  );

  mix_src_sel #(.MIX_W(MIX_W)) u_sel (
    .clk        (clk),
    .rst        (rst),
    .load_pulse (load_pulse),
    .load_word  (load_word),
    .rom_req    (rom_req),
    .src_mode   (src_mode),
    .ext_factor (ext_factor),
    .rom_enter  (rom_enter)
  );

  mix_quarter_rom #(.MIX_W(MIX_W)) u_rom (
    .clk     (clk),
    .rst     (rst),
    .restart (rom_enter),
    .advance (smp_valid && rom_active),
    .value   (rom_value)
  );

  assign eff_factor = rom_active ? rom_value : ext_factor;

  mix_mult_stage #(.DATA_W(DATA_W), .MIX_W(MIX_W)) u_mult (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (smp_valid),
    .in_data   (smp_data),
    .factor    (eff_factor),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/tune_mixer_chk.sv
module tune_mixer_chk #(
  parameter int unsigned DATA_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic [DATA_W-1:0] smp_data,
  input logic              mix_sd,
  input logic              mix_frame,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              rom_active
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0)); // R1

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (out_valid == $past(smp_valid))); // R2

  AST_LOAD_EXT: assert property (@(posedge clk) disable iff (rst)
    (mix_frame ##1 !mix_frame) |=> !rom_active); // R3

  AST_ROM_SELECT: assert property (@(posedge clk) disable iff (rst)
    (!mix_frame ##1 (!mix_frame && mix_sd)) |=> rom_active); // R5

  AST_ZERO_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(smp_valid) && $past(smp_data) == '0) |-> out_data == '0); // R7

  AST_FRAME_KEEPS_SRC: assert property (@(posedge clk) disable iff (rst)
    mix_frame |=> $stable(rom_active)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(smp_valid)) |-> $stable(out_data)); // R10

endmodule

bind tune_mixer tune_mixer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_valid  (smp_valid),
  .smp_data   (smp_data),
  .mix_sd     (mix_sd),
  .mix_frame  (mix_frame),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .rom_active (rom_active)
);

// File: tb/test_tune_mixer.sv
module test_tune_mixer;

  localparam logic [23:0] POS = 24'h7FFFFF;
  localparam logic [23:0] NEG = 24'h800001;

  // {sample, factor}
  localparam logic [47:0] VEC [0:7] = '{
    48'h000400_400000,
    48'hFFFC00_400000,
    48'h7FFFFF_7FFFFF,
    48'h800000_800000,
    48'h123456_C00000,
    48'h000001_400000,
    48'hFFFFFF_400000,
    48'h800000_7FFFFF
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic        mix_sd = 1'b0;
  logic        mix_frame = 1'b0;
  logic        out_valid;
  logic [23:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tune_mixer i_tune_mixer (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .mix_sd    (mix_sd),
    .mix_frame (mix_frame),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [23:0] ref_mix(logic [23:0] x, logic [23:0] m, output bit clip);
    longint p;
    p = longint'(signed'(x)) * longint'(signed'(m));
    p = (p + 64'sd4194304) >>> 23;
    clip = 1'b0;
    if (p > 64'sd8388607) begin
      clip = 1'b1;
      return 24'h7FFFFF;
    end
    if (p < -64'sd8388608) begin
      clip = 1'b1;
      return 24'h800000;
    end
    return p[23:0];
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_factor(logic [23:0] m);
    for (int i = 23; i >= 0; i--) begin
      mix_frame = 1'b1;
      mix_sd    = m[i];
      @(negedge clk);
    end
    mix_frame = 1'b0;
    mix_sd    = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(logic [23:0] x, logic [23:0] m, string tag);
    bit c;
    logic [23:0] e;
    smp_valid = 1'b1;
    smp_data  = x;
    @(negedge clk);
    smp_valid = 1'b0;
    e = ref_mix(x, m, c);
    check("R2 valid", {23'b0, out_valid}, 24'd1);
    check(c ? "R8" : tag, out_data, e);
  endtask

  task automatic select_rom();
    mix_frame = 1'b0;
    mix_sd    = 1'b1;
    @(negedge clk);
    mix_sd    = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] keep;
    bit c;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {23'b0, out_valid}, 24'd0);
    check("R1 data in reset", out_data, 24'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after release", {23'b0, out_valid}, 24'd0);
    send(24'h100000, 24'h000000, "R1 zero factor");

    // Table of external factors: R3 MSB-first load, R7 rounding, R8 clip
    foreach (VEC[k]) begin
      load_factor(VEC[k][23:0]);
      send(VEC[k][47:24], VEC[k][23:0], "R3/R7");
    end

    // R10: idle clock keeps data, valid drops
    keep = out_data;
    @(negedge clk);
    check("R10 hold", out_data, keep);
    check("R2 idle valid", {23'b0, out_valid}, 24'd0);

    // R4: sample on the commit clock uses the old factor
    load_factor(24'h200000);
    for (int i = 23; i >= 0; i--) begin
      mix_frame = 1'b1;
      mix_sd    = 24'h600000 >> i;
      @(negedge clk);
    end
    mix_frame = 1'b0;
    mix_sd    = 1'b0;
    smp_valid = 1'b1;
    smp_data  = 24'h010000;
    @(negedge clk);
    smp_valid = 1'b0;
    check("R4 old factor", out_data, ref_mix(24'h010000, 24'h200000, c));
    send(24'h010000, 24'h600000, "R4 new factor");

    // R5/R6: table sequence with idle gaps
    select_rom();
    send(24'd1000, 24'h000000, "R6 entry0");
    repeat (2) @(negedge clk);
    send(24'd1000, POS, "R6 entry1");
    send(-24'd5000, 24'h000000, "R6 entry2");
    send(-24'd5000, NEG, "R6 entry3");
    send(24'h7FFFFF, 24'h000000, "R6 wrap");

    // R9: sample in the middle of a load stays on the table (entry1)
    for (int i = 23; i >= 0; i--) begin
      mix_frame = 1'b1;
      mix_sd    = 24'hA00000 >> i;
      smp_valid = (i == 12);
      smp_data  = 24'h300000;
      @(negedge clk);
      if (i == 12) check("R9 table during load", out_data, ref_mix(24'h300000, POS, c));
    end
    smp_valid = 1'b0;
    mix_frame = 1'b0;
    mix_sd    = 1'b0;
    @(negedge clk);
    send(24'h300000, 24'hA00000, "R3 ext after load");

    // R5: re-entering the table restarts at entry 0
    select_rom();
    send(24'h300000, 24'h000000, "R5 restart entry0");
    send(24'h300000, POS, "R5 restart entry1");

    // R1: reset mid-run clears factor and mode
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 data mid reset", out_data, 24'd0);
    rst = 1'b0;
    @(negedge clk);
    send(24'h123456, 24'h000000, "R1 factor cleared");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule